// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides which clocks of a small microcontroller run in any given master clock cycle. Software asks for idle, software power down or slow-down through register-bit inputs. A dedicated active-low pin forces hardware power down. An interrupt-pending line and two candidate wake-up pins end the low-power states. The block drives three outputs: a clock enable for the CPU, a clock enable for the peripherals and an oscillator-run signal. It also reports the present mode on a 3-bit status field.

Slow-down is a divide-by-32 of the clock enables. It applies on top of normal or idle operation. Leaving either power-down state passes through a fixed oscillator restart delay before the clocks come back. After hardware power down, a system reset request is also held during that restart. A register bit picks the wake-up pin for software power down.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the status is 0 (normal), both clock enables and `osc_run` are 1, and `sys_rst_req` is 0.
- R2: In normal mode, `req_idle` moves the block to idle at the next clock edge: status 1, `cpu_clk_en` 0, `per_clk_en` 1, `osc_run` 1. Software requests are ignored in every other mode.
- R3: In idle, `irq_pend` high returns the block to normal at the next edge. In normal mode `irq_pend` has no effect.
- R4: In normal mode, `req_pdown` enters software power down at the next edge: status 2, both enables 0, `osc_run` 0. If `req_pdown` and `req_idle` arrive together, power down wins.
- R5: Software power down is left only through the selected wake pin. That pin passes a two-flop synchronizer and must read low in two consecutive synchronized cycles, so the block leaves at the 4th edge after the pin falls. A one-cycle low and `irq_pend` are ignored.
- R6: `wake_sel` = 1 selects `wake_pin_b` and `wake_sel` = 0 selects `wake_pin_a`. The unselected pin has no effect.
- R7: After a software power-down wake-up, `osc_run` is 1 and both enables stay 0 with status 2 for 16 cycles. Then the block is in normal mode.
- R8: `hw_pd_n` low is synchronized by two flops and forces hardware power down at the 3rd edge, from any mode. In that mode the status is 3, both enables are 0, `osc_run` is 0 and `sys_rst_req` is 1.
- R9: When `hw_pd_n` returns high, the 3rd edge starts a 16-cycle restart (status 3, `osc_run` 1, enables 0, `sys_rst_req` 1). Normal mode follows with `sys_rst_req` 0.
- R10: With `slow_req` high (registered at the next edge), both enables pulse together for one cycle in every 32, spaced exactly 32 cycles apart. Status bit 2 is set in normal and idle.
- R11: Slow-down combines with idle: status 5, `cpu_clk_en` stays 0, and `per_clk_en` pulses once every 32 cycles.
- R12: Asynchronous reset from any mode immediately restores the R1 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_idle | input | 1 | Software idle request |
| req_pdown | input | 1 | Software power-down request |
| slow_req | input | 1 | Slow-down enable register bit |
| wake_sel | input | 1 | Wake pin select (1 = pin B) |
| hw_pd_n | input | 1 | Hardware power-down pin, active low |
| irq_pend | input | 1 | Interrupt pending |
| wake_pin_a | input | 1 | Wake pin A (external interrupt line) |
| wake_pin_b | input | 1 | Wake pin B (alternate receive line) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run |
| sys_rst_req | output | 1 | System reset request during hardware power-down exit |
| mode_o | output | 3 | [1:0] mode code, [2] slow-down active |

## Verification
Software requests and `irq_pend` act at the first clock edge, so the bench drives them at a falling edge and checks at the next falling edge. The pin paths take longer. A hardware power-down change shows at the 3rd edge and a wake-up at the 4th, so the bench checks the old state one edge before and the new state on the due edge. Restart windows are sampled in each of their 16 cycles and once after. Slow-down is judged over 64-cycle windows by pulse count and spacing, which removes any dependence on the phase of the divider.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SPD    = 3'd2,
        ST_HPD    = 3'd3,
        ST_WAKE_S = 3'd4,
        ST_WAKE_H = 3'd5
    } pmc_state_e;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_IDLE   = 2'd1;
    localparam logic [1:0] MODE_SPD    = 2'd2;
    localparam logic [1:0] MODE_HPD    = 2'd3;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= {RST_VAL, RST_VAL};
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.s2;

    // R5: the synchronized output is the input as it stood two edges earlier
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sy_q.s2 == $past(sy_q.s1)));

endmodule

// File: rtl/pmc_slow_div.sv
module pmc_slow_div #(
    parameter int unsigned RATIO = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned DW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [DW-1:0] LAST = DW'(RATIO - 1);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        if (div_q == LAST) div_d = '0;
        else               div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick_o = (div_q == LAST);

    // R10: the counter wraps to zero right after the tick
    a_r10_div_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (div_q == '0));
    // R10: ticks never fall on back-to-back cycles
    a_r10_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/pmc_wake_det.sv
module pmc_wake_det #(
    parameter int unsigned LOW_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic sel_i,
    input  logic pin_a_s,
    input  logic pin_b_s,
    output logic wake_o
);
    localparam int unsigned CW = $clog2(LOW_MIN + 1);
    localparam logic [CW-1:0] SAT  = CW'(LOW_MIN);
    localparam logic [CW-1:0] NEED = CW'(LOW_MIN - 1);

    logic [CW-1:0] run_d, run_q;
    logic          sel_low;

    assign sel_low = sel_i ? !pin_b_s : !pin_a_s;

    always_comb begin
        if (!arm_i || !sel_low) run_d = '0;
        else if (run_q < SAT)   run_d = run_q + 1'b1;
        else                    run_d = run_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign wake_o = arm_i && sel_low && (run_q >= NEED);

    // R5: a wake needs the selected pin low while armed in the previous cycle too
    a_r5_two_lows: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(arm_i && sel_low));

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int unsigned RESTART = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_idle,
    input  logic       req_pdown,
    input  logic       slow_req,
    input  logic       irq_pend,
    input  logic       hpd_n_s,
    input  logic       wake_i,
    input  logic       tick_i,
    output logic       arm_o,
    output logic       cpu_en_o,
    output logic       per_en_o,
    output logic       osc_o,
    output logic       sys_rst_o,
    output logic [2:0] mode_o
);
    localparam int unsigned RW = (RESTART > 1) ? $clog2(RESTART) : 1;
    localparam logic [RW-1:0] LOAD = RW'(RESTART - 1);

    typedef struct packed {
        pmc_state_e     st;
        logic [RW-1:0]  cnt;
        logic           slow;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.slow = slow_req;
        if (!hpd_n_s) begin
            r_d.st   = ST_HPD;
            r_d.cnt  = '0;
            r_d.slow = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_RUN: begin
                    if (req_pdown)     r_d.st = ST_SPD;
                    else if (req_idle) r_d.st = ST_IDLE;
                end
                ST_IDLE: begin
                    if (irq_pend) r_d.st = ST_RUN;
                end
                ST_SPD: begin
                    if (wake_i) begin
                        r_d.st  = ST_WAKE_S;
                        r_d.cnt = LOAD;
                    end
                end
                ST_HPD: begin
                    r_d.st   = ST_WAKE_H;
                    r_d.cnt  = LOAD;
                    r_d.slow = 1'b0;
                end
                ST_WAKE_S, ST_WAKE_H: begin
                    if (r_q.st == ST_WAKE_H) r_d.slow = 1'b0;
                    if (r_q.cnt == '0) r_d.st  = ST_RUN;
                    else               r_d.cnt = r_q.cnt - 1'b1;
                end
                default: r_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RUN;
            r_q.cnt  <= '0;
            r_q.slow <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    logic clk_slot;
    logic run_st;
    logic idle_st;

    assign clk_slot = !r_q.slow || tick_i;
    assign run_st   = (r_q.st == ST_RUN);
    assign idle_st  = (r_q.st == ST_IDLE);

    assign arm_o     = (r_q.st == ST_SPD);
    assign cpu_en_o  = run_st && clk_slot;
    assign per_en_o  = (run_st || idle_st) && clk_slot;
    assign osc_o     = !((r_q.st == ST_SPD) || (r_q.st == ST_HPD));
    assign sys_rst_o = (r_q.st == ST_HPD) || (r_q.st == ST_WAKE_H);

    always_comb begin
        unique case (r_q.st)
            ST_IDLE:              mode_o[1:0] = MODE_IDLE;
            ST_SPD, ST_WAKE_S:    mode_o[1:0] = MODE_SPD;
            ST_HPD, ST_WAKE_H:    mode_o[1:0] = MODE_HPD;
            default:              mode_o[1:0] = MODE_NORMAL;
        endcase
        mode_o[2] = r_q.slow && (run_st || idle_st);
    end

    // R3: a pending interrupt ends idle on the next edge
    a_r3_irq_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && irq_pend && hpd_n_s) |=> (r_q.st == ST_RUN));
    // R5: software power down holds until a wake-up
    a_r5_spd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SPD && !wake_i && hpd_n_s) |=> (r_q.st == ST_SPD));
    // R8: hardware power down overrides every mode
    a_r8_hpd_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !hpd_n_s |=> (r_q.st == ST_HPD));
    // R7: the restart ends in normal mode
    a_r7_restart_done: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAKE_S && r_q.cnt == '0 && hpd_n_s) |=> (r_q.st == ST_RUN));
    // R9: leaving hardware power down goes through the reset request
    a_r9_exit_via_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HPD && hpd_n_s) |=> (r_q.st == ST_WAKE_H && sys_rst_o));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int unsigned SLOW_RATIO     = 32,
    parameter int unsigned RESTART_CYCLES = 16,
    parameter int unsigned WAKE_LOW_MIN   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_idle,
    input  logic       req_pdown,
    input  logic       slow_req,
    input  logic       wake_sel,
    input  logic       hw_pd_n,
    input  logic       irq_pend,
    input  logic       wake_pin_a,
    input  logic       wake_pin_b,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_run,
    output logic       sys_rst_req,
    output logic [2:0] mode_o
);
    localparam int unsigned NPIN = 3;

    logic [NPIN-1:0] pins_s;
    logic            tick;
    logic            wake;
    logic            arm;

    pmc_sync #(.W(NPIN), .RST_VAL({NPIN{1'b1}})) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hw_pd_n, wake_pin_b, wake_pin_a}),
        .sync_o  (pins_s)
    );

    pmc_slow_div #(.RATIO(SLOW_RATIO)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    pmc_wake_det #(.LOW_MIN(WAKE_LOW_MIN)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (arm),
        .sel_i   (wake_sel),
        .pin_a_s (pins_s[0]),
        .pin_b_s (pins_s[1]),
        .wake_o  (wake)
    );

    pmc_fsm #(.RESTART(RESTART_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_idle  (req_idle),
        .req_pdown (req_pdown),
        .slow_req  (slow_req),
        .irq_pend  (irq_pend),
        .hpd_n_s   (pins_s[2]),
        .wake_i    (wake),
        .tick_i    (tick),
        .arm_o     (arm),
        .cpu_en_o  (cpu_clk_en),
        .per_en_o  (per_clk_en),
        .osc_o     (osc_run),
        .sys_rst_o (sys_rst_req),
        .mode_o    (mode_o)
    );

    // R2: the CPU clock never runs while the peripherals are stopped
    a_r2_cpu_implies_per: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> per_clk_en);
    // R4: with the oscillator off no clock enable is given
    a_r4_osc_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> (!per_clk_en && !cpu_clk_en));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
    localparam time CLK_P = 20ns;

    logic clk = 1'b0;
    logic rst_n, req_idle, req_pdown, slow_req, wake_sel, hw_pd_n, irq_pend;
    logic wake_pin_a, wake_pin_b;
    logic cpu_clk_en, per_clk_en, osc_run, sys_rst_req;
    logic [2:0] mode_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    pwr_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_pdown(req_pdown),
        .slow_req(slow_req), .wake_sel(wake_sel), .hw_pd_n(hw_pd_n),
        .irq_pend(irq_pend), .wake_pin_a(wake_pin_a), .wake_pin_b(wake_pin_b),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
        .sys_rst_req(sys_rst_req), .mode_o(mode_o)
    );

    function automatic logic [6:0] exp_v(int m, bit c, bit p, bit o, bit s);
        return {m[2:0], c, p, o, s};
    endfunction

    function automatic logic [6:0] got_v();
        return {mode_o, cpu_clk_en, per_clk_en, osc_run, sys_rst_req};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input bit b, input logic v);
        if (b) wake_pin_b = v;
        else   wake_pin_a = v;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 0; req_idle = 0; req_pdown = 0; slow_req = 0; wake_sel = 0;
        hw_pd_n = 1; irq_pend = 0; wake_pin_a = 1; wake_pin_b = 1;
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1 reset state", got_v(), exp_v(0, 1, 1, 1, 0));

        // R3: interrupt in normal mode changes nothing
        irq_pend = 1; cyc(1); irq_pend = 0;
        chk("R3 irq in normal", got_v(), exp_v(0, 1, 1, 1, 0));

        // R2: idle entry
        req_idle = 1; cyc(1); req_idle = 0;
        chk("R2 idle entry", got_v(), exp_v(1, 0, 1, 1, 0));
        req_pdown = 1; cyc(3); req_pdown = 0;
        chk("R2 request ignored in idle", got_v(), exp_v(1, 0, 1, 1, 0));
        irq_pend = 1; cyc(1); irq_pend = 0;
        chk("R3 irq leaves idle", got_v(), exp_v(0, 1, 1, 1, 0));

        // software power down, both wake selections
        for (int sel = 0; sel < 2; sel++) begin
            wake_sel = sel[0];
            req_pdown = 1; req_idle = 1; cyc(1); req_pdown = 0; req_idle = 0;
            chk("R4 pdown entry wins", got_v(), exp_v(2, 0, 0, 0, 0));
            irq_pend = 1; cyc(3); irq_pend = 0;
            chk("R5 irq ignored in pdown", got_v(), exp_v(2, 0, 0, 0, 0));
            set_pin(!sel[0], 1'b0); cyc(6); set_pin(!sel[0], 1'b1);
            chk("R6 unselected pin ignored", got_v(), exp_v(2, 0, 0, 0, 0));
            set_pin(sel[0], 1'b0); cyc(1); set_pin(sel[0], 1'b1); cyc(5);
            chk("R5 short low ignored", got_v(), exp_v(2, 0, 0, 0, 0));
            set_pin(sel[0], 1'b0); cyc(3);
            chk("R5 no wake at edge 3", got_v(), exp_v(2, 0, 0, 0, 0));
            cyc(1);
            chk("R6 selected pin wakes at edge 4", got_v(), exp_v(2, 0, 0, 1, 0));
            set_pin(sel[0], 1'b1);
            for (int i = 1; i < 16; i++) begin
                cyc(1);
                chk("R7 restart window", got_v(), exp_v(2, 0, 0, 1, 0));
            end
            cyc(1);
            chk("R7 normal after restart", got_v(), exp_v(0, 1, 1, 1, 0));
        end

        // hardware power down from normal, idle and software power down
        for (int m = 0; m < 3; m++) begin
            if (m == 1) begin req_idle = 1; cyc(1); req_idle = 0; end
            if (m == 2) begin req_pdown = 1; cyc(1); req_pdown = 0; end
            hw_pd_n = 0; cyc(2);
            chk("R8 mode kept before edge 3", 32'(mode_o), 32'(m));
            cyc(1);
            chk("R8 hpd entry", got_v(), exp_v(3, 0, 0, 0, 1));
            req_idle = 1; irq_pend = 1; cyc(4); req_idle = 0; irq_pend = 0;
            chk("R8 hpd held", got_v(), exp_v(3, 0, 0, 0, 1));
            hw_pd_n = 1; cyc(2);
            chk("R9 hpd until edge 3", got_v(), exp_v(3, 0, 0, 0, 1));
            cyc(1);
            chk("R9 restart with reset request", got_v(), exp_v(3, 0, 0, 1, 1));
            for (int i = 1; i < 16; i++) begin
                cyc(1);
                chk("R9 restart window", got_v(), exp_v(3, 0, 0, 1, 1));
            end
            cyc(1);
            chk("R9 normal after restart", got_v(), exp_v(0, 1, 1, 1, 0));
        end

        // R10: slow-down in normal mode
        slow_req = 1; cyc(1);
        begin
            int nc = 0, np = 0, mis = 0, badm = 0, first = -1, second = -1;
            for (int i = 0; i < 64; i++) begin
                if (cpu_clk_en) begin
                    nc++;
                    if (first < 0) first = i; else second = i;
                end
                if (per_clk_en) np++;
                if (cpu_clk_en !== per_clk_en) mis++;
                if (mode_o !== 3'd4) badm++;
                cyc(1);
            end
            chk("R10 cpu pulses per 64", nc, 2);
            chk("R10 periph pulses per 64", np, 2);
            chk("R10 pulse spacing", second - first, 32);
            chk("R10 cpu and periph aligned", mis, 0);
            chk("R10 status slow bit", badm, 0);
        end

        // R11: slow-down combined with idle
        req_idle = 1; cyc(1); req_idle = 0;
        chk("R11 idle slow status", 32'(mode_o), 5);
        begin
            int nc = 0, np = 0;
            for (int i = 0; i < 64; i++) begin
                if (cpu_clk_en) nc++;
                if (per_clk_en) np++;
                cyc(1);
            end
            chk("R11 cpu stopped", nc, 0);
            chk("R11 periph pulses", np, 2);
        end
        irq_pend = 1; cyc(1); irq_pend = 0;
        chk("R11 back to slow normal", 32'(mode_o), 4);
        slow_req = 0; cyc(1);
        begin
            int nc = 0;
            for (int i = 0; i < 8; i++) begin
                if (cpu_clk_en && per_clk_en) nc++;
                cyc(1);
            end
            chk("R10 full rate after slow off", nc, 8);
        end

        // R12: asynchronous reset out of each power-down mode
        req_pdown = 1; cyc(1); req_pdown = 0;
        chk("R12 in pdown before reset", 32'(mode_o), 2);
        rst_n = 0; #1;
        chk("R12 reset leaves pdown", got_v(), exp_v(0, 1, 1, 1, 0));
        cyc(1); rst_n = 1; cyc(1);
        hw_pd_n = 0; cyc(3);
        chk("R12 in hpd before reset", 32'(mode_o), 3);
        hw_pd_n = 1; rst_n = 0; #1;
        chk("R12 reset leaves hpd", got_v(), exp_v(0, 1, 1, 1, 0));
        cyc(1); rst_n = 1; cyc(4);
        chk("R12 normal after reset", got_v(), exp_v(0, 1, 1, 1, 0));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule